// File: doc/BRIEF.md
# LPC Host Interrupt Status and Mask Unit

This block gathers every interrupt cause of an LPC host controller into one 32-bit status word. The word has a mask register with the same bit layout, and the block drives a single interrupt line. Two kinds of source share the word. Serial IRQ lines come from an upstream deserializer as levels. Error, reset and bus-master request events come from the bus engine as short pulses. Every implemented status bit is a sticky latch that software clears by writing a 1 to it. A level source that is still active sets its bit again on the following clock. Software can therefore clear a serial IRQ after servicing it, and the bit stays up while the device keeps its line asserted.

When any of the six bus error events fires, the block also records the bus address of the failing cycle in a separate read-only register. A handler can then report where the fault happened. Software reaches all three registers through a small port with an address, a write strobe, write data and read data. The write takes effect at the clock edge, and the read is combinational.

Top module: `lpcirq_unit`

## Requirements
- R1: Status bit positions: serial IRQ n (0..16) at bit 31-n, bus reset at bit 10, bus-master request 0 at bit 1, request 1 at bit 0. The error event input index k (0..5) sits at bit k+2. Index 0 is bus-master turnaround, 1 target turnaround, 2 timeout, 3 normal SYNC error, 4 no response, 5 abnormal SYNC. Bits 14:11 and 9:8 always read 0 in both the status and the mask register.
- R2: A status bit reads 1 from the clock edge after its source is high, and stays set after the source falls. Status reads are the same whatever the mask.
- R3: At offset 0x38, writing 1 to a status bit clears it at the next edge. Writing 0 leaves the bit unchanged.
- R4: A serial IRQ bit that is cleared while its input is still high is set again. Once the input is low, a clearing write leaves it at 0.
- R5: When a source event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: While the bus reset input is held high, the reset bit is set again on every clock, so a clearing write has no lasting effect.
- R7: The mask register at offset 0x34 is written at the edge and reads back its implemented bits.
- R8: irq_o equals the OR over all bits of status AND mask, following the registers with no extra delay. With the mask at 0, irq_o is low.
- R9: The register at offset 0x40 takes cyc_addr_i on every edge where any of the six error inputs is high. No other input changes it: not serial IRQs, not bus reset, not bus-master requests.
- R10: After reset, status, mask and error address are 0. Any other offset reads 0, and writes to 0x40 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| serirq_i | input | 17 | Deserialized serial IRQ levels, index = IRQ number |
| lreset_i | input | 1 | Bus reset active indication |
| buserr_i | input | 6 | Bus error event pulses, index per R1 |
| bmreq_i | input | 2 | Bus-master request events 0 and 1 |
| cyc_addr_i | input | 32 | Address of the bus cycle in progress |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The directed cases cover four places where a design can go wrong. A clear issued while a serial IRQ or the bus reset is still active must leave the bit set; a design that lets the clear win would lose a pending interrupt. An event and a clear in the same cycle must also leave the bit set, which catches a design that gives the write priority. A walk through every source, one at a time, catches a swapped or reversed bit position. The error address must track the latest error only, so a design that also captured on request or reset events would hold the wrong address. Random traffic then mixes writes, levels and pulses, and every register and irq_o is compared with a model after each cycle.

// File: rtl/lpcirq_pkg.sv
package lpcirq_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int BUS_ADDR_W = 32;
    localparam int SER_N      = 17;
    localparam int ERR_N      = 6;
    localparam int BMREQ_N    = 2;

    // bit positions that software decodes
    localparam int SER_TOP  = WORD_W - 1;
    localparam int LRST_BIT = 10;
    localparam int ERR_LSB  = 2;

    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_EADDR = 8'h40;

    typedef struct packed {
        logic [SER_N-1:0]   serirq;
        logic               lrst;
        logic [ERR_N-1:0]   err;
        logic [BMREQ_N-1:0] bmreq;
    } irq_src_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_EADDR
    } reg_sel_e;

    typedef struct packed {
        logic              wr_mask;
        logic              wr_stat;
        logic [WORD_W-1:0] wdata;
    } reg_wr_t;

    // place each source on its status bit
    function automatic logic [WORD_W-1:0] map_sources(irq_src_t s);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int n = 0; n < SER_N; n++) begin
            v[SER_TOP-n] = s.serirq[n];
        end
        v[LRST_BIT] = s.lrst;
        for (int k = 0; k < ERR_N; k++) begin
            v[ERR_LSB+k] = s.err[k];
        end
        // request 0 sits above request 1
        for (int b = 0; b < BMREQ_N; b++) begin
            v[BMREQ_N-1-b] = s.bmreq[b];
        end
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] implemented_bits();
        irq_src_t all;
        all = '1;
        return map_sources(all);
    endfunction

    function automatic reg_sel_e decode(logic [ADDR_W-1:0] a);
        case (a)
            OFF_MASK:  return SEL_MASK;
            OFF_STAT:  return SEL_STAT;
            OFF_EADDR: return SEL_EADDR;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lpcirq_stat_bit.sv
module lpcirq_stat_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // a source event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> q_o);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        (!q_o && !set_i) |=> !q_o);

endmodule

// File: rtl/lpcirq_stat_bank.sv
module lpcirq_stat_bank
    import lpcirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] clr_i,
    output logic [WORD_W-1:0] stat_o
);

    localparam logic [WORD_W-1:0] IMPL = implemented_bits();

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_latch
            lpcirq_stat_bit u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (src_i[i]),
                .clr_i (clr_i[i]),
                .q_o   (stat_o[i])
            );
        end else begin : g_rsvd
            assign stat_o[i] = 1'b0;
        end
    end

    logic unused_bits;
    assign unused_bits = ^(src_i & ~IMPL) ^ ^(clr_i & ~IMPL);

endmodule

// File: rtl/lpcirq_err_addr.sv
module lpcirq_err_addr
    import lpcirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ERR_N-1:0]      err_i,
    input  logic [BUS_ADDR_W-1:0] addr_i,
    output logic [BUS_ADDR_W-1:0] addr_o
);

    logic capture;
    assign capture = |err_i;

    always_ff @(posedge clk) begin
        if (rst)
            addr_o <= '0;
        else if (capture)
            addr_o <= addr_i;
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (|err_i) |=> (addr_o == $past(addr_i)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(|err_i) |=> $stable(addr_o));

endmodule

// File: rtl/lpcirq_unit.sv
module lpcirq_unit
    import lpcirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic [SER_N-1:0]      serirq_i,
    input  logic                  lreset_i,
    input  logic [ERR_N-1:0]      buserr_i,
    input  logic [BMREQ_N-1:0]    bmreq_i,
    input  logic [BUS_ADDR_W-1:0] cyc_addr_i,
    output logic                  irq_o
);

    localparam logic [WORD_W-1:0] IMPL = implemented_bits();

    reg_sel_e          sel;
    reg_wr_t           wr;
    irq_src_t          src;
    logic [WORD_W-1:0] src_vec;
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] mask_q;
    logic [BUS_ADDR_W-1:0] eaddr_q;

    assign sel = decode(reg_addr);

    always_comb begin
        wr.wr_mask = reg_wr_en && (sel == SEL_MASK);
        wr.wr_stat = reg_wr_en && (sel == SEL_STAT);
        wr.wdata   = reg_wdata;
    end

    always_comb begin
        src.serirq = serirq_i;
        src.lrst   = lreset_i;
        src.err    = buserr_i;
        src.bmreq  = bmreq_i;
    end

    assign src_vec = map_sources(src);

    lpcirq_stat_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_vec),
        .clr_i  (wr.wr_stat ? wr.wdata : '0),
        .stat_o (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr.wr_mask)
            mask_q <= wr.wdata & IMPL;
    end

    lpcirq_err_addr u_eaddr (
        .clk    (clk),
        .rst    (rst),
        .err_i  (buserr_i),
        .addr_i (cyc_addr_i),
        .addr_o (eaddr_q)
    );

    assign irq_o = |(stat_q & mask_q);

    always_comb begin
        case (sel)
            SEL_MASK:  reg_rdata = mask_q;
            SEL_STAT:  reg_rdata = stat_q;
            SEL_EADDR: reg_rdata = eaddr_q;
            default:   reg_rdata = '0;
        endcase
    end

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr.wr_mask |=> (mask_q == ($past(reg_wdata) & IMPL)));
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_mask |=> $stable(mask_q));
    assert_masked_off_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o);
    assert_lreset_held_R6: assert property (@(posedge clk) disable iff (rst)
        lreset_i |=> stat_q[LRST_BIT]);

endmodule

// File: tb/lpcirq_unit_test.sv
module lpcirq_unit_test;

    localparam logic [31:0] IMPL = 32'hFFFF_84FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [16:0] serirq_i = '0;
    logic        lreset_i = 1'b0;
    logic [5:0]  buserr_i = '0;
    logic [1:0]  bmreq_i = '0;
    logic [31:0] cyc_addr_i = '0;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] m_stat = '0, m_mask = '0, m_eaddr = '0;

    lpcirq_unit uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_i(serirq_i),
        .lreset_i(lreset_i), .buserr_i(buserr_i), .bmreq_i(bmreq_i),
        .cyc_addr_i(cyc_addr_i), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] src_vec(logic [16:0] s, logic l,
                                            logic [5:0] e, logic [1:0] b);
        logic [31:0] v = '0;
        for (int n = 0; n < 17; n++) if (s[n]) v = v | (32'h8000_0000 >> n);
        if (l) v = v | 32'h0000_0400;
        for (int k = 0; k < 6; k++) if (e[k]) v = v | (32'h4 << k);
        if (b[0]) v = v | 32'h2;
        if (b[1]) v = v | 32'h1;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // one clock with the current inputs; model follows the requirements
    task automatic cycle();
        logic [31:0] clr, n_stat, n_mask, n_eaddr;
        clr     = (reg_wr_en && reg_addr == 8'h38) ? reg_wdata : '0;
        n_stat  = (src_vec(serirq_i, lreset_i, buserr_i, bmreq_i) | (m_stat & ~clr)) & IMPL;
        n_mask  = (reg_wr_en && reg_addr == 8'h34) ? (reg_wdata & IMPL) : m_mask;
        n_eaddr = (|buserr_i) ? cyc_addr_i : m_eaddr;
        @(posedge clk);
        #2;
        m_stat = n_stat; m_mask = n_mask; m_eaddr = n_eaddr;
        reg_wr_en = 1'b0;
        check("R8 irq", {31'b0, irq_o}, {31'b0, |(m_stat & m_mask)});
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        reg_wr_en = 1'b0;
        reg_addr  = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
    endtask

    task automatic idle_srcs();
        serirq_i = '0; lreset_i = 1'b0; buserr_i = '0; bmreq_i = '0;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] layout [7];
        int seed_v;
        seed_v = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R10 reset values and unmapped offsets
        rd(8'h38, 32'h0, "R10 status reset");
        rd(8'h34, 32'h0, "R10 mask reset");
        rd(8'h40, 32'h0, "R10 eaddr reset");
        rd(8'h20, 32'h0, "R10 unmapped read");
        check("R10 irq reset", {31'b0, irq_o}, 32'h0);

        // R1 walk each source alone
        layout[0] = 32'h8000_0000; layout[1] = 32'h0000_8000; layout[2] = 32'h0000_0400;
        layout[3] = 32'h0000_0080; layout[4] = 32'h0000_0004; layout[5] = 32'h0000_0002;
        layout[6] = 32'h0000_0001;
        for (int i = 0; i < 7; i++) begin
            idle_srcs();
            case (i)
                0: serirq_i[0] = 1'b1;
                1: serirq_i[16] = 1'b1;
                2: lreset_i = 1'b1;
                3: buserr_i[5] = 1'b1;
                4: buserr_i[0] = 1'b1;
                5: bmreq_i[0] = 1'b1;
                default: bmreq_i[1] = 1'b1;
            endcase
            cycle();
            idle_srcs();
            rd(8'h38, layout[i], "R1 bit position");
            wr(8'h38, 32'hFFFF_FFFF);
            rd(8'h38, 32'h0, "R3 clear all");
        end

        // R1 reserved bits read 0
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, IMPL, "R1 R7 mask reserved bits");
        wr(8'h34, 32'h0);

        // R2 R4 level serial IRQ
        serirq_i[3] = 1'b1;
        cycle();
        rd(8'h38, 32'h1000_0000, "R2 serirq latched, mask off");
        check("R8 masked off", {31'b0, irq_o}, 32'h0);
        wr(8'h34, 32'h1000_0000);
        check("R8 irq with mask", {31'b0, irq_o}, 32'h1);
        wr(8'h38, 32'h1000_0000);
        rd(8'h38, 32'h1000_0000, "R4 reasserts while held");
        serirq_i[3] = 1'b0;
        cycle();
        rd(8'h38, 32'h1000_0000, "R2 sticky after drop");
        wr(8'h38, 32'h1000_0000);
        rd(8'h38, 32'h0, "R4 cleared after drop");
        check("R8 irq gone", {31'b0, irq_o}, 32'h0);

        // R9 R3 error pulse and address
        buserr_i[2] = 1'b1; cyc_addr_i = 32'hCAFE_0010;
        cycle();
        buserr_i = '0; cyc_addr_i = 32'h1111_1111;
        cycle();
        rd(8'h38, 32'h0000_0010, "R2 timeout latched");
        rd(8'h40, 32'hCAFE_0010, "R9 address captured");
        wr(8'h38, 32'hFFFF_FFEF);
        rd(8'h38, 32'h0000_0010, "R3 write zero keeps");
        // R5 event and clear together
        buserr_i[2] = 1'b1; cyc_addr_i = 32'hBEEF_0020;
        wr(8'h38, 32'h0000_0010);
        buserr_i = '0;
        rd(8'h38, 32'h0000_0010, "R5 event wins");
        rd(8'h40, 32'hBEEF_0020, "R9 most recent");
        wr(8'h38, 32'h0000_0010);
        rd(8'h38, 32'h0, "R3 one clears");
        // R9 non-error sources leave address
        serirq_i[1] = 1'b1; bmreq_i = 2'b11; lreset_i = 1'b1; cyc_addr_i = 32'h0BAD_0BAD;
        cycle();
        idle_srcs();
        rd(8'h40, 32'hBEEF_0020, "R9 no capture on others");
        wr(8'h40, 32'h1234_5678);
        rd(8'h40, 32'hBEEF_0020, "R10 eaddr write ignored");
        wr(8'h38, 32'hFFFF_FFFF);

        // R6 reset held
        lreset_i = 1'b1;
        cycle();
        wr(8'h38, 32'h0000_0400);
        rd(8'h38, 32'h0000_0400, "R6 clear while held");
        lreset_i = 1'b0;
        cycle();
        wr(8'h38, 32'h0000_0400);
        rd(8'h38, 32'h0, "R6 clear after release");

        // random mix checked against model
        for (int t = 0; t < 2000; t++) begin
            logic [31:0] r;
            r = $urandom;
            serirq_i = $urandom & (((r[3:0] == 0)) ? 17'h1FFFF : 17'h00421);
            lreset_i = (r[7:4] == 0);
            buserr_i = (r[11:8] == 0) ? 6'($urandom) : 6'h0;
            bmreq_i  = (r[13:12] == 0) ? 2'($urandom) : 2'h0;
            cyc_addr_i = $urandom;
            reg_wr_en = r[14];
            case (r[17:15])
                3'd0, 3'd1: reg_addr = 8'h34;
                3'd2, 3'd3, 3'd4: reg_addr = 8'h38;
                3'd5: reg_addr = 8'h40;
                default: reg_addr = 8'($urandom);
            endcase
            reg_wdata = $urandom;
            cycle();
            rd(8'h38, m_stat, "R2 R3 R5 random status");
            rd(8'h34, m_mask, "R7 random mask");
            rd(8'h40, m_eaddr, "R9 random eaddr");
        end

        report();
    end

endmodule